// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block issues raw command and address cycles to a NAND flash device. It supports three operations: a page read, a read of the spare (out-of-band) area, and a block erase. When a start pulse arrives, the block captures the operation, the block number, the page number and the column. It converts these into a row address and an effective column. It then waits until the device's ready/busy line, passed through a synchroniser, reports ready. After that it drives a fixed-width bus cycle for each byte of the command, with the command latch or the address latch raised and the write strobe pulsed low in the middle of the cycle.

After the final command byte, the block waits a fixed settling interval so the device can pull its busy line low. It then waits for ready again and pulses `done_o` for one clock. A read leaves the chip selected so that a separate data-path agent can fetch the page. An erase deselects the chip when it completes. The bus-width flag halves the column on 16-bit devices, and the five-cycle flag adds the third row byte needed by larger devices.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset, `ce_n_o` and `we_n_o` are high and `cle_o`, `ale_o`, `dq_oe_o` and `done_o` are low.
- R2: The row address is `page_i + block_i * PAGES_PER_BLOCK`. It is sent low byte first: bits 7:0, then bits 15:8.
- R3: `op_i` = 0 (read) sends these bytes in order: command 0x00, column bits 7:0, column bits 15:8, the row bytes, then command 0x30. The value 3 behaves exactly like 0.
- R4: `op_i` = 1 (spare-area read) sends command 0x00 and then the column `col_i + PAGE_BYTES`, followed by the same remainder as a read.
- R5: For reads with `bus16_i` high, the column that is sent is the (possibly spare-adjusted) column shifted right by one.
- R6: With `five_cyc_i` high, a third row byte follows the first two. It carries row bits 19:16 in its low nibble and zero in its upper nibble. With the flag low, the byte is absent.
- R7: `op_i` = 2 (erase) sends command 0x60, then the row bytes, then command 0xD0. After the device reports ready, `ce_n_o` is high in the same cycle that `done_o` pulses.
- R8: No write-strobe pulse occurs while `rb_n_i` is low before the first command byte of an operation.
- R9: After the final command byte, `done_o` stays low while `rb_n_i` is low. It rises exactly three clocks after `rb_n_i` returns high, and it is a single-cycle pulse.
- R10: Each byte is latched by the rising edge of `we_n_o`. The strobe stays low for `CYC_CLKS - 2*(CYC_CLKS/4)` clocks. During that time exactly one of `cle_o` and `ale_o` is high, `dq_oe_o` is high, and `dq_o`, `cle_o` and `ale_o` are steady.
- R11: A start pulse received while an operation is in flight is ignored. No extra bytes are sent and no extra done pulse occurs.
- R12: After a read or spare-area read completes, `ce_n_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request; accepted only when idle |
| op_i | input | 2 | 0 read, 1 spare-area read, 2 erase, 3 read |
| block_i | input | BLOCK_W | Erase-block number |
| page_i | input | log2(PAGES_PER_BLOCK) | Page within the block |
| col_i | input | 16 | Byte column within the page |
| bus16_i | input | 1 | Device has a 16-bit data bus |
| five_cyc_i | input | 1 | Device needs a third row-address byte |
| rb_n_i | input | 1 | Device ready (high) / busy (low), asynchronous |
| ce_n_o | output | 1 | Chip enable, active low |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_n_o | output | 1 | Write strobe, active low |
| dq_o | output | 8 | Command or address byte |
| dq_oe_o | output | 1 | Drive enable for `dq_o` |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with `CYC_CLKS` = 6 and `TWB_CLKS` = 4, and leaves the page size, pages per block and 14-bit block number at their defaults. A 6-clock cycle gives a 4-clock strobe with one idle clock on each side, so the bench can see both the strobe width and the hold of the latch signals around it. A 14-bit block number times 64 pages reaches row bit 19, so the third row byte carries a non-zero nibble. A 2048-byte page pushes the spare-area column into the high column byte, where the 16-bit halving is visible in both bytes.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_SPARE = 2'd1,
        OP_ERASE = 2'd2,
        OP_ALT   = 2'd3
    } nand_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_BUS,
        ST_SETTLE,
        ST_POST
    } seq_state_e;

    localparam logic [7:0] OPC_READ0  = 8'h00;
    localparam logic [7:0] OPC_RSTART = 8'h30;
    localparam logic [7:0] OPC_ERASE1 = 8'h60;
    localparam logic [7:0] OPC_ERASE2 = 8'hD0;

    localparam int ROW_BITS = 20;
    localparam int COL_BITS = 16;
    localparam int IDX_BITS = 3;

    // One entry of the byte sequence
    typedef struct packed {
        logic       is_cmd;
        logic       is_last;
        logic [7:0] data;
    } bus_step_t;

endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_n_async,
    output logic ready_sync
);
    logic [STAGES-1:0] sh_q;

    // Resets to "busy" so nothing is issued before a real sample.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= rb_n_async;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= {sh_q[STAGES-2:0], rb_n_async};
            end
        end
    endgenerate

    assign ready_sync = sh_q[STAGES-1];
endmodule

// File: rtl/nand_addr_gen.sv
module nand_addr_gen
    import nand_seq_pkg::*;
#(
    parameter int PAGE_BYTES      = 2048,
    parameter int PAGES_PER_BLOCK = 64,
    parameter int BLOCK_W         = 14,
    localparam int PAGE_W         = $clog2(PAGES_PER_BLOCK)
) (
    input  nand_op_e              op_i,
    input  logic [BLOCK_W-1:0]    block_i,
    input  logic [PAGE_W-1:0]     page_i,
    input  logic [COL_BITS-1:0]   col_i,
    input  logic                  bus16_i,
    output logic [ROW_BITS-1:0]   row_o,
    output logic [COL_BITS-1:0]   col_o
);
    logic [COL_BITS-1:0] col_adj;

    always_comb begin
        row_o = ROW_BITS'(block_i) * ROW_BITS'(PAGES_PER_BLOCK) + ROW_BITS'(page_i);

        // Spare area sits directly after the data bytes of the page.
        col_adj = col_i;
        if (op_i == OP_SPARE) begin
            col_adj = col_i + COL_BITS'(PAGE_BYTES);
        end

        // Wide devices count columns in 16-bit words.
        col_o = col_adj;
        if (bus16_i && (op_i != OP_ERASE)) begin
            col_o = col_adj >> 1;
        end
    end
endmodule

// File: rtl/nand_step_table.sv
module nand_step_table
    import nand_seq_pkg::*;
(
    input  nand_op_e              op_i,
    input  logic [IDX_BITS-1:0]   idx_i,
    input  logic                  five_i,
    input  logic [COL_BITS-1:0]   col_i,
    input  logic [ROW_BITS-1:0]   row_i,
    output bus_step_t             step_o
);
    logic [7:0] row_top;

    assign row_top = {4'h0, row_i[19:16]};

    always_comb begin
        step_o = '0;
        if (op_i == OP_ERASE) begin
            case (idx_i)
                3'd0: begin
                    step_o.is_cmd = 1'b1;
                    step_o.data   = OPC_ERASE1;
                end
                3'd1: step_o.data = row_i[7:0];
                3'd2: step_o.data = row_i[15:8];
                3'd3: begin
                    if (five_i) begin
                        step_o.data = row_top;
                    end else begin
                        step_o.is_cmd  = 1'b1;
                        step_o.is_last = 1'b1;
                        step_o.data    = OPC_ERASE2;
                    end
                end
                default: begin
                    step_o.is_cmd  = 1'b1;
                    step_o.is_last = 1'b1;
                    step_o.data    = OPC_ERASE2;
                end
            endcase
        end else begin
            case (idx_i)
                3'd0: begin
                    step_o.is_cmd = 1'b1;
                    step_o.data   = OPC_READ0;
                end
                3'd1: step_o.data = col_i[7:0];
                3'd2: step_o.data = col_i[15:8];
                3'd3: step_o.data = row_i[7:0];
                3'd4: step_o.data = row_i[15:8];
                3'd5: begin
                    if (five_i) begin
                        step_o.data = row_top;
                    end else begin
                        step_o.is_cmd  = 1'b1;
                        step_o.is_last = 1'b1;
                        step_o.data    = OPC_RSTART;
                    end
                end
                default: begin
                    step_o.is_cmd  = 1'b1;
                    step_o.is_last = 1'b1;
                    step_o.data    = OPC_RSTART;
                end
            endcase
        end
    end
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int PAGE_BYTES      = 2048,
    parameter int PAGES_PER_BLOCK = 64,
    parameter int BLOCK_W         = 14,
    parameter int CYC_CLKS        = 4,
    parameter int TWB_CLKS        = 8,
    parameter int SYNC_STAGES     = 2,
    localparam int PAGE_W         = $clog2(PAGES_PER_BLOCK)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [1:0]          op_i,
    input  logic [BLOCK_W-1:0]  block_i,
    input  logic [PAGE_W-1:0]   page_i,
    input  logic [15:0]         col_i,
    input  logic                bus16_i,
    input  logic                five_cyc_i,
    input  logic                rb_n_i,
    output logic                ce_n_o,
    output logic                cle_o,
    output logic                ale_o,
    output logic                we_n_o,
    output logic [7:0]          dq_o,
    output logic                dq_oe_o,
    output logic                done_o
);
    localparam int CNT_MAX   = (CYC_CLKS > TWB_CLKS) ? CYC_CLKS : TWB_CLKS;
    localparam int CNT_W     = $clog2(CNT_MAX + 1);
    localparam int WE_LO_BEG = CYC_CLKS / 4;
    localparam int WE_LO_END = CYC_CLKS - CYC_CLKS / 4;

    typedef struct packed {
        seq_state_e            st;
        nand_op_e              op;
        logic                  five;
        logic [COL_BITS-1:0]   col;
        logic [ROW_BITS-1:0]   row;
        logic [IDX_BITS-1:0]   idx;
        logic [CNT_W-1:0]      cnt;
        logic                  ce_n;
        logic                  cle;
        logic                  ale;
        logic                  we_n;
        logic                  oe;
        logic                  done;
        logic [7:0]            dq;
    } seq_regs_t;

    localparam seq_regs_t REGS_RST = '{
        st: ST_IDLE, op: OP_READ, five: 1'b0, col: '0, row: '0,
        idx: '0, cnt: '0, ce_n: 1'b1, cle: 1'b0, ale: 1'b0,
        we_n: 1'b1, oe: 1'b0, done: 1'b0, dq: '0
    };

    seq_regs_t           r_d, r_q;
    logic                rdy_s;
    logic [ROW_BITS-1:0] row_calc;
    logic [COL_BITS-1:0] col_calc;
    bus_step_t           cur_step;
    logic                op_is_erase;
    logic                we_window;

    nand_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .rb_n_async (rb_n_i),
        .ready_sync (rdy_s)
    );

    nand_addr_gen #(
        .PAGE_BYTES      (PAGE_BYTES),
        .PAGES_PER_BLOCK (PAGES_PER_BLOCK),
        .BLOCK_W         (BLOCK_W)
    ) u_addr (
        .op_i    (nand_op_e'(op_i)),
        .block_i (block_i),
        .page_i  (page_i),
        .col_i   (col_i),
        .bus16_i (bus16_i),
        .row_o   (row_calc),
        .col_o   (col_calc)
    );

    nand_step_table u_steps (
        .op_i   (r_q.op),
        .idx_i  (r_q.idx),
        .five_i (r_q.five),
        .col_i  (r_q.col),
        .row_i  (r_q.row),
        .step_o (cur_step)
    );

    assign op_is_erase = (r_q.op == OP_ERASE);
    assign we_window   = (r_q.cnt >= CNT_W'(WE_LO_BEG)) && (r_q.cnt < CNT_W'(WE_LO_END));

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.cle  = 1'b0;
        r_d.ale  = 1'b0;
        r_d.oe   = 1'b0;
        r_d.we_n = 1'b1;
        r_d.dq   = 8'h00;

        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.op   = nand_op_e'(op_i);
                    r_d.five = five_cyc_i;
                    r_d.col  = col_calc;
                    r_d.row  = row_calc;
                    r_d.st   = ST_PRE;
                end
            end
            ST_PRE: begin
                if (rdy_s) begin
                    r_d.st   = ST_BUS;
                    r_d.idx  = '0;
                    r_d.cnt  = '0;
                    r_d.ce_n = 1'b0;
                end
            end
            ST_BUS: begin
                r_d.cle  = cur_step.is_cmd;
                r_d.ale  = !cur_step.is_cmd;
                r_d.oe   = 1'b1;
                r_d.dq   = cur_step.data;
                r_d.we_n = !we_window;
                if (r_q.cnt == CNT_W'(CYC_CLKS - 1)) begin
                    r_d.cnt = '0;
                    if (cur_step.is_last) begin
                        r_d.st = ST_SETTLE;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_SETTLE: begin
                if (r_q.cnt == CNT_W'(TWB_CLKS - 1)) begin
                    r_d.cnt = '0;
                    r_d.st  = ST_POST;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_POST: begin
                if (rdy_s) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    if (op_is_erase) begin
                        r_d.ce_n = 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign ce_n_o  = r_q.ce_n;
    assign cle_o   = r_q.cle;
    assign ale_o   = r_q.ale;
    assign we_n_o  = r_q.we_n;
    assign dq_o    = r_q.dq;
    assign dq_oe_o = r_q.oe;
    assign done_o  = r_q.done;
endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       cle,
    input logic       ale,
    input logic       we_n,
    input logic [7:0] dq,
    input logic       oe,
    input logic       done,
    input logic       ready_sync,
    input logic       erase_sel
);
    // R10: one latch strobe per write pulse
    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (cle ^ ale));

    // R10: byte and latch lines steady across the low strobe
    a_r10_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> ($stable(cle) && $stable(ale) && $stable(dq)));

    // R10: data driven whenever a latch line is up
    a_r10_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (cle || ale) |-> oe);

    // R10: chip selected under every strobe
    a_r10_ce_low: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !ce_n);

    // R9: completion is one cycle wide
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: completion only follows a ready sample
    a_r9_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(ready_sync));

    // R7: erase releases the chip with its completion
    a_r7_erase_release: assert property (@(posedge clk) disable iff (!rst_n)
        (done && erase_sel) |-> ce_n);

    // R12: reads keep the chip selected
    a_r12_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !erase_sel) |-> !ce_n);
endmodule

bind nand_cmd_seq nand_cmd_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n_o),
    .cle        (cle_o),
    .ale        (ale_o),
    .we_n       (we_n_o),
    .dq         (dq_o),
    .oe         (dq_oe_o),
    .done       (done_o),
    .ready_sync (rdy_s),
    .erase_sel  (op_is_erase)
);

// File: tb/nand_cmd_seq_bench.sv
module nand_cmd_seq_bench;
    localparam int PB  = 2048;
    localparam int PPB = 64;
    localparam int BW  = 14;
    localparam int PW  = 6;
    localparam int CYC = 6;
    localparam int TWB = 4;
    localparam int WE_LO = CYC - 2 * (CYC / 4);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    op = 2'd0;
    logic [BW-1:0] blk = '0;
    logic [PW-1:0] pg = '0;
    logic [15:0]   col = '0;
    logic          b16 = 1'b0;
    logic          five = 1'b0;
    logic          rb_n = 1'b1;
    logic          ce_n, cle, ale, we_n, oe, done;
    logic [7:0]    dq;

    nand_cmd_seq #(
        .PAGE_BYTES(PB), .PAGES_PER_BLOCK(PPB), .BLOCK_W(BW),
        .CYC_CLKS(CYC), .TWB_CLKS(TWB)
    ) u_nand_cmd_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op),
        .block_i(blk), .page_i(pg), .col_i(col), .bus16_i(b16),
        .five_cyc_i(five), .rb_n_i(rb_n), .ce_n_o(ce_n), .cle_o(cle),
        .ale_o(ale), .we_n_o(we_n), .dq_o(dq), .dq_oe_o(oe), .done_o(done)
    );

    always #4 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    // Device-side capture: bytes latch on the rising strobe
    logic [9:0] lat [0:15];
    int         n_lat = 0;
    logic [9:0] exp_b [0:15];
    int         n_exp = 0;
    int         cur_lo = 0;
    int         n_pulse = 0;
    int         bad_width = 0;

    always @(posedge we_n) begin
        if (rst_n) begin
            if (n_lat < 16) lat[n_lat] = {cle, ale, dq};
            n_lat = n_lat + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && we_n === 1'b0) begin
            cur_lo = cur_lo + 1;
        end else if (cur_lo > 0) begin
            if (cur_lo != WE_LO) bad_width = bad_width + 1;
            n_pulse = n_pulse + 1;
            cur_lo = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic push(input bit c, input logic [7:0] b);
        exp_b[n_exp] = {c, !c, b};
        n_exp++;
    endtask

    task automatic build_exp(input int o, input int bk, input int pgn, input int cl,
                             input bit w16, input bit f5);
        int row;
        int c;
        row = pgn + bk * PPB;
        c = cl;
        if (o == 1) c = c + PB;
        if (w16 && o != 2) c = c >> 1;
        c = c & 16'hFFFF;
        n_exp = 0;
        if (o == 2) begin
            push(1'b1, 8'h60);
            push(1'b0, row[7:0]);
            push(1'b0, row[15:8]);
            if (f5) push(1'b0, {4'h0, row[19:16]});
            push(1'b1, 8'hD0);
        end else begin
            push(1'b1, 8'h00);
            push(1'b0, c[7:0]);
            push(1'b0, c[15:8]);
            push(1'b0, row[7:0]);
            push(1'b0, row[15:8]);
            if (f5) push(1'b0, {4'h0, row[19:16]});
            push(1'b1, 8'h30);
        end
    endtask

    task automatic launch(input int o, input int bk, input int pgn, input int cl,
                          input bit w16, input bit f5);
        build_exp(o, bk, pgn, cl, w16, f5);
        n_lat = 0;
        @(negedge clk);
        op = o[1:0]; blk = bk[BW-1:0]; pg = pgn[PW-1:0]; col = cl[15:0];
        b16 = w16; five = f5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Wait for the final byte, model busy, check completion timing
    task automatic finish_op(input int busy, input string tag);
        for (int k = 0; k < 2000 && n_lat < n_exp; k++) @(negedge clk);
        if (busy > 0) begin
            int early;
            early = 0;
            rb_n = 1'b0;
            for (int k = 0; k < busy; k++) begin
                @(negedge clk);
                if (done) early++;
            end
            rb_n = 1'b1;
            chk(early == 0, {tag, " R9 done during busy"}, early, 0);
            @(negedge clk);
            chk(done == 1'b0, {tag, " R9 done after 1 clk"}, done, 0);
            @(negedge clk);
            chk(done == 1'b0, {tag, " R9 done after 2 clk"}, done, 0);
            @(negedge clk);
            chk(done == 1'b1, {tag, " R9 done after 3 clk"}, done, 1);
        end else begin
            for (int k = 0; k < 200 && !done; k++) @(negedge clk);
            chk(done == 1'b1, {tag, " R9 done seen"}, done, 1);
        end
    endtask

    task automatic check_seq(input string tag);
        chk(n_lat == n_exp, {tag, " byte count"}, n_lat, n_exp);
        for (int i = 0; i < n_exp && i < n_lat && i < 16; i++) begin
            chk(lat[i] === exp_b[i], $sformatf("%s byte %0d", tag, i), lat[i], exp_b[i]);
        end
    endtask

    task automatic t_reset();
        chk(ce_n == 1'b1 && we_n == 1'b1, "R1 ce_n/we_n after reset", {ce_n, we_n}, 2'b11);
        chk(cle == 1'b0 && ale == 1'b0, "R1 cle/ale after reset", {cle, ale}, 2'b00);
        chk(oe == 1'b0 && done == 1'b0, "R1 oe/done after reset", {oe, done}, 2'b00);
    endtask

    task automatic t_read_basic();
        launch(0, 3, 5, 16'h123, 1'b0, 1'b0);
        finish_op(20, "R3 read");
        chk(ce_n == 1'b0, "R12 ce held after read", ce_n, 0);
        check_seq("R2 R3 read four-cycle");
        @(negedge clk);
        chk(done == 1'b0, "R9 done single pulse", done, 0);
    endtask

    task automatic t_read_five();
        launch(3, 14'h3ABC, 5, 16'h7FF, 1'b0, 1'b1);
        finish_op(12, "R6 read five");
        check_seq("R6 R3 five-cycle read, op 3");
    endtask

    task automatic t_spare();
        launch(1, 7, 9, 16'h10, 1'b0, 1'b0);
        finish_op(0, "R4 spare");
        check_seq("R4 spare column");
    endtask

    task automatic t_wide();
        launch(0, 1, 2, 16'h246, 1'b1, 1'b0);
        finish_op(0, "R5 wide read");
        check_seq("R5 wide read column");
        launch(1, 2, 0, 16'h20, 1'b1, 1'b1);
        finish_op(6, "R5 wide spare");
        check_seq("R5 R4 wide spare column");
    endtask

    task automatic t_erase();
        launch(2, 14'h3ABC, 0, 16'hFFFF, 1'b1, 1'b1);
        finish_op(40, "R7 erase five");
        chk(ce_n == 1'b1, "R7 ce released at done", ce_n, 1);
        check_seq("R7 erase five-cycle");
        launch(2, 14'h0155, 3, 16'h0, 1'b0, 1'b0);
        finish_op(0, "R7 erase four");
        chk(ce_n == 1'b1, "R7 ce released (four)", ce_n, 1);
        check_seq("R7 erase four-cycle");
    endtask

    task automatic t_pre_wait();
        int strobes;
        rb_n = 1'b0;
        launch(0, 9, 1, 16'h40, 1'b0, 1'b0);
        strobes = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (we_n == 1'b0) strobes++;
        end
        chk(strobes == 0 && n_lat == 0, "R8 no strobe while busy", strobes + n_lat, 0);
        rb_n = 1'b1;
        finish_op(8, "R8 after release");
        check_seq("R8 sequence after release");
    endtask

    task automatic t_ignore_start();
        int dones;
        launch(0, 4, 4, 16'h88, 1'b0, 1'b0);
        for (int k = 0; k < 200 && n_lat < 2; k++) @(negedge clk);
        op = 2'd2; blk = 14'h1234; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_op(10, "R11 busy start");
        check_seq("R11 original op kept");
        dones = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (done) dones++;
        end
        chk(dones == 0 && n_lat == n_exp, "R11 no extra op", dones + n_lat, n_exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_read_basic();
        t_read_five();
        t_spare();
        t_wide();
        t_erase();
        t_pre_wait();
        t_ignore_start();
        chk(n_pulse > 0 && bad_width == 0, "R10 strobe width", bad_width, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule